// File: doc/BRIEF.md
# Bit-manipulation integer ALU

A purely combinational 64-bit integer execution unit for a 64-bit RISC core that also carries the bit-manipulation extensions. Each cycle it takes two 64-bit operands and a 7-bit operation code and returns a 64-bit result together with a branch-taken flag. It performs shifts and rotates, single-bit clear, set, invert and extract, 32-bit word forms whose results are sign-extended, a family of adds (plain, low-word, odd, right-shifted-src1 and left-shifted-src1), subtract, set-less-than and min/max, logic with an inverted second operand, byte and halfword packing, sign extension, bit and byte reversal, and conditional-branch comparison.

The three upper opcode bits pick an operation group, and the four lower bits pick the operation inside it. Every opcode that is not defined below produces a zero result with the branch flag low. The result and flag follow the inputs within the same cycle. A register stage, if one is wanted, belongs to the surrounding pipeline.

Top module: `bmalu_top`

## Requirements
- R1: The opcode group is given by opcode bits [6:4]: 000 shift/bit, 001 word, 010 add, 011 subtract/compare, 100 and 101 logic/pack, 110 truncated logic, 111 branch. Any opcode not listed in R2 to R12 gives result 0 and br_taken 0.
- R2: With amount k = src_b[5:0]: 0x00 gives (zero-extended src_a[31:0]) << k, 0x01 src_a << k, 0x02 clears bit k of src_a, 0x03 sets it, 0x04 inverts it, 0x05 logical right shift, 0x06 returns bit k of src_a in bit 0 with all other bits zero, and 0x07 arithmetic right shift.
- R3: 0x08 rotates src_a left and 0x09 rotates it right by src_b[5:0]. 0x1C rotates src_a[31:0] left and 0x1D rotates it right by src_b[4:0], with the 32-bit result sign-extended. A rotate by zero returns the operand unchanged.
- R4: Word codes give bits [31:0] sign-extended to 64 bits: 0x10 src_a+src_b, 0x11 src_a[0]+src_b, 0x12 src_a-src_b, 0x18 src_a<<src_b[4:0], 0x19 src_a[31:0] logically shifted right, 0x1A src_a[31:0] arithmetically shifted right.
- R5: From the sum src_a+src_b, 0x14 returns bit 0 only, 0x15 the low byte zero-extended, 0x16 the low 16 bits zero-extended, and 0x17 the low 16 bits sign-extended.
- R6: 0x20 returns zero-extended src_a[31:0] + src_b, 0x21 src_a+src_b, 0x22 src_a[0]+src_b, and 0x24/0x25/0x26/0x27 return (src_a logically shifted right by 29/30/31/32) + src_b.
- R7: Left-shifted adds return (x << n) + src_b: 0x29/0x2B/0x2D with x = src_a and n = 1/2/3, 0x28/0x2A/0x2C with x = zero-extended src_a[31:0] and n = 1/2/3, and 0x2F with x = src_a and n = 4.
- R8: 0x30 returns src_a-src_b. 0x31 returns 1 when src_a < src_b unsigned, and 0x32 returns 1 when src_a < src_b signed, else 0. 0x34/0x35 return the unsigned maximum/minimum and 0x36/0x37 the signed maximum/minimum.
- R9: 0x40 and, 0x41 src_a & ~src_b, 0x42 or, 0x43 src_a | ~src_b, 0x44 xor, 0x45 xnor. 0x46 maps each byte of src_a to 0xFF if it is nonzero and to 0x00 otherwise.
- R10: 0x48 sign-extends src_a[7:0], and 0x4A sign-extends src_a[15:0]. 0x49 returns {src_b[7:0],src_a[7:0]} zero-extended. 0x4B returns {src_b[15:0],src_a[15:0]} sign-extended. 0x50 reverses the bit order inside every byte, 0x51 reverses the byte order, and 0x52 returns {src_b[31:0],src_a[31:0]}.
- R11: Codes 0x60 to 0x67 take the logic result of code 0x40 + {op[2:1],0} (and, or, xor, byte-or-combine). With op[0]=0 they return only its bit 0, and with op[0]=1 its low 16 bits zero-extended.
- R12: Branch codes assert br_taken for 0x70 src_a==src_b, 0x72 not equal, 0x78 signed less-than, 0x7A signed greater-or-equal, 0x7C unsigned less-than and 0x7E unsigned greater-or-equal. Their result is 0, and br_taken is 0 for every non-branch opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 7 | Operation code; bits [6:4] choose the group |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand; supplies shift amount and bit index in its low bits |
| result | output | 64 | Operation result, zero for branches and undefined codes |
| br_taken | output | 1 | Branch condition met for a branch opcode |

## Verification
All 128 opcode values are run, the undefined ones included, against a crossed grid of corner operands: zero, all-ones, the most negative value, the most positive value, one, shift amounts 31, 32 and 63, and a value whose only set bit is bit 31. This grid tells signed from unsigned comparison and arithmetic from logical shift. It shows whether word results are truncated and sign-extended at bit 31 or at bit 63, and whether rotates by 0, 32 and 63 wrap correctly. Random operand pairs on every opcode then expose carry-chain and byte-lane mistakes in the adds, the packs and the reversals that the sparse corner values cannot reach.

// File: rtl/bmalu_pkg.sv
package bmalu_pkg;
  localparam int XLEN    = 64;
  localparam int WLEN    = 32;
  localparam int HLEN    = 16;
  localparam int BLEN    = 8;
  localparam int OP_W    = 7;
  localparam int FN_W    = 4;
  localparam int SH_W    = $clog2(XLEN);
  localparam int WSH_W   = $clog2(WLEN);
  localparam int NBYTES  = XLEN / BLEN;

  typedef enum logic [2:0] {
    GRP_SHIFT = 3'b000,
    GRP_WORD  = 3'b001,
    GRP_ADD   = 3'b010,
    GRP_CMP   = 3'b011,
    GRP_LOGA  = 3'b100,
    GRP_LOGB  = 3'b101,
    GRP_LOGT  = 3'b110,
    GRP_BR    = 3'b111
  } grp_e;

  function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] w);
    return {{(XLEN-WLEN){w[WLEN-1]}}, w};
  endfunction

  function automatic logic [XLEN-1:0] rot_left(input logic [XLEN-1:0] x, input logic [SH_W-1:0] k);
    logic [SH_W-1:0] back;
    back = SH_W'(0) - k;
    return (x << k) | (x >> back);
  endfunction

  function automatic logic [XLEN-1:0] rot_right(input logic [XLEN-1:0] x, input logic [SH_W-1:0] k);
    logic [SH_W-1:0] back;
    back = SH_W'(0) - k;
    return (x >> k) | (x << back);
  endfunction

  function automatic logic [WLEN-1:0] wrot_left(input logic [WLEN-1:0] x, input logic [WSH_W-1:0] k);
    logic [WSH_W-1:0] back;
    back = WSH_W'(0) - k;
    return (x << k) | (x >> back);
  endfunction

  function automatic logic [WLEN-1:0] wrot_right(input logic [WLEN-1:0] x, input logic [WSH_W-1:0] k);
    logic [WSH_W-1:0] back;
    back = WSH_W'(0) - k;
    return (x >> k) | (x << back);
  endfunction

  function automatic logic [XLEN-1:0] byte_or_combine(input logic [XLEN-1:0] x);
    logic [XLEN-1:0] r;
    for (int i = 0; i < NBYTES; i++) r[i*BLEN +: BLEN] = {BLEN{|x[i*BLEN +: BLEN]}};
    return r;
  endfunction

  function automatic logic [XLEN-1:0] bits_in_bytes_rev(input logic [XLEN-1:0] x);
    logic [XLEN-1:0] r;
    for (int i = 0; i < NBYTES; i++)
      for (int j = 0; j < BLEN; j++) r[i*BLEN + j] = x[i*BLEN + BLEN-1 - j];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] byte_order_rev(input logic [XLEN-1:0] x);
    logic [XLEN-1:0] r;
    for (int i = 0; i < NBYTES; i++) r[i*BLEN +: BLEN] = x[(NBYTES-1-i)*BLEN +: BLEN];
    return r;
  endfunction

  // sel: 0 and, 1 andn, 2 or, 3 orn, 4 xor, 5 xnor, 6 byte-or-combine of a
  function automatic logic [XLEN-1:0] logic_core(input logic [2:0] sel, input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b);
    case (sel)
      3'd0:    return a & b;
      3'd1:    return a & ~b;
      3'd2:    return a | b;
      3'd3:    return a | ~b;
      3'd4:    return a ^ b;
      3'd5:    return ~(a ^ b);
      3'd6:    return byte_or_combine(a);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/bmalu_decode.sv
module bmalu_decode
  import bmalu_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output grp_e            grp,
  output logic            op_legal
);
  logic [FN_W-1:0] fn;
  assign fn  = op_code[FN_W-1:0];
  assign grp = grp_e'(op_code[OP_W-1:FN_W]);

  always_comb begin
    case (grp)
      GRP_SHIFT: op_legal = (fn <= 4'd9);
      GRP_WORD:  op_legal = !(fn inside {4'd3, 4'd11, 4'd14, 4'd15});
      GRP_ADD:   op_legal = !(fn inside {4'd3, 4'd14});
      GRP_CMP:   op_legal = (fn <= 4'd7) && (fn != 4'd3);
      GRP_LOGA:  op_legal = (fn <= 4'd11) && (fn != 4'd7);
      GRP_LOGB:  op_legal = (fn <= 4'd2);
      GRP_LOGT:  op_legal = !fn[3];
      GRP_BR:    op_legal = !fn[0] && (fn[3:2] != 2'b01);
      default:   op_legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/bmalu_shift.sv
module bmalu_shift
  import bmalu_pkg::*;
(
  input  logic [FN_W-1:0] fn,
  input  logic [XLEN-1:0] a,
  input  logic [SH_W-1:0] sh,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] bit_mask;
  logic [XLEN-1:0] a_lo;
  assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << sh;
  assign a_lo     = {{(XLEN-WLEN){1'b0}}, a[WLEN-1:0]};

  always_comb begin
    case (fn)
      4'd0:    res = a_lo << sh;
      4'd1:    res = a << sh;
      4'd2:    res = a & ~bit_mask;
      4'd3:    res = a | bit_mask;
      4'd4:    res = a ^ bit_mask;
      4'd5:    res = a >> sh;
      4'd6:    res = {{(XLEN-1){1'b0}}, |(a & bit_mask)};
      4'd7:    res = XLEN'($signed(a) >>> sh);
      4'd8:    res = rot_left(a, sh);
      4'd9:    res = rot_right(a, sh);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/bmalu_arith.sv
module bmalu_arith
  import bmalu_pkg::*;
(
  input  logic [FN_W-1:0] fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] word_res,
  output logic [XLEN-1:0] add_res,
  output logic [XLEN-1:0] cmp_res,
  output logic            cond_met
);
  localparam logic [SH_W-1:0] SR_BASE = SH_W'(29);

  logic [XLEN-1:0]  sum, diff, odd_sum, a_lo;
  logic [WLEN-1:0]  lw;
  logic [WSH_W-1:0] ws;
  logic             lt_s, lt_u;

  assign sum     = a + b;
  assign diff    = a - b;
  assign odd_sum = {{(XLEN-1){1'b0}}, a[0]} + b;
  assign lw      = a[WLEN-1:0];
  assign a_lo    = {{(XLEN-WLEN){1'b0}}, lw};
  assign ws      = b[WSH_W-1:0];
  assign lt_s    = $signed(a) < $signed(b);
  assign lt_u    = a < b;

  always_comb begin
    case (fn)
      4'd0:    word_res = sext_word(sum[WLEN-1:0]);
      4'd1:    word_res = sext_word(odd_sum[WLEN-1:0]);
      4'd2:    word_res = sext_word(diff[WLEN-1:0]);
      4'd4:    word_res = {{(XLEN-1){1'b0}}, sum[0]};
      4'd5:    word_res = {{(XLEN-BLEN){1'b0}}, sum[BLEN-1:0]};
      4'd6:    word_res = {{(XLEN-HLEN){1'b0}}, sum[HLEN-1:0]};
      4'd7:    word_res = {{(XLEN-HLEN){sum[HLEN-1]}}, sum[HLEN-1:0]};
      4'd8:    word_res = sext_word(lw << ws);
      4'd9:    word_res = sext_word(lw >> ws);
      4'd10:   word_res = sext_word(WLEN'($signed(lw) >>> ws));
      4'd12:   word_res = sext_word(wrot_left(lw, ws));
      4'd13:   word_res = sext_word(wrot_right(lw, ws));
      default: word_res = '0;
    endcase
  end

  always_comb begin
    case (fn)
      4'd0:                  add_res = a_lo + b;
      4'd1:                  add_res = sum;
      4'd2:                  add_res = odd_sum;
      4'd4, 4'd5, 4'd6, 4'd7: add_res = (a >> (SR_BASE + SH_W'(fn[1:0]))) + b;
      4'd8:                  add_res = (a_lo << 1) + b;
      4'd9:                  add_res = (a << 1) + b;
      4'd10:                 add_res = (a_lo << 2) + b;
      4'd11:                 add_res = (a << 2) + b;
      4'd12:                 add_res = (a_lo << 3) + b;
      4'd13:                 add_res = (a << 3) + b;
      4'd15:                 add_res = (a << 4) + b;
      default:               add_res = '0;
    endcase
  end

  always_comb begin
    case (fn)
      4'd0:    cmp_res = diff;
      4'd1:    cmp_res = {{(XLEN-1){1'b0}}, lt_u};
      4'd2:    cmp_res = {{(XLEN-1){1'b0}}, lt_s};
      4'd4:    cmp_res = lt_u ? b : a;
      4'd5:    cmp_res = lt_u ? a : b;
      4'd6:    cmp_res = lt_s ? b : a;
      4'd7:    cmp_res = lt_s ? a : b;
      default: cmp_res = '0;
    endcase
  end

  // fn[3:2] picks the comparison, fn[1] inverts it
  always_comb begin
    case (fn[3:2])
      2'b00:   cond_met = (a == b) ^ fn[1];
      2'b10:   cond_met = lt_s ^ fn[1];
      2'b11:   cond_met = lt_u ^ fn[1];
      default: cond_met = 1'b0;
    endcase
  end
endmodule

// File: rtl/bmalu_logic.sv
module bmalu_logic
  import bmalu_pkg::*;
(
  input  grp_e            grp,
  input  logic [FN_W-1:0] fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] plain_res, pack_res, rev_res, trunc_src;

  assign trunc_src = logic_core({fn[2:1], 1'b0}, a, b);

  always_comb begin
    case (fn)
      4'd8:    pack_res = {{(XLEN-BLEN){a[BLEN-1]}}, a[BLEN-1:0]};
      4'd9:    pack_res = {{(XLEN-2*BLEN){1'b0}}, b[BLEN-1:0], a[BLEN-1:0]};
      4'd10:   pack_res = {{(XLEN-HLEN){a[HLEN-1]}}, a[HLEN-1:0]};
      4'd11:   pack_res = sext_word({b[HLEN-1:0], a[HLEN-1:0]});
      default: pack_res = '0;
    endcase
    plain_res = fn[3] ? pack_res : logic_core(fn[2:0], a, b);
  end

  always_comb begin
    case (fn)
      4'd0:    rev_res = bits_in_bytes_rev(a);
      4'd1:    rev_res = byte_order_rev(a);
      4'd2:    rev_res = {b[WLEN-1:0], a[WLEN-1:0]};
      default: rev_res = '0;
    endcase
  end

  always_comb begin
    case (grp)
      GRP_LOGA: res = plain_res;
      GRP_LOGB: res = rev_res;
      GRP_LOGT: res = fn[0] ? {{(XLEN-HLEN){1'b0}}, trunc_src[HLEN-1:0]}
                            : {{(XLEN-1){1'b0}}, trunc_src[0]};
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/bmalu_top.sv
module bmalu_top
  import bmalu_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] result,
  output logic            br_taken
);
  grp_e            grp;
  logic            op_legal;
  logic            cond_met;
  logic [XLEN-1:0] shift_res, word_res, add_res, cmp_res, logic_res;
  logic [FN_W-1:0] fn;

  assign fn = op_code[FN_W-1:0];

  bmalu_decode u_decode (.op_code(op_code), .grp(grp), .op_legal(op_legal));

  bmalu_shift u_shift (.fn(fn), .a(src_a), .sh(src_b[SH_W-1:0]), .res(shift_res));

  bmalu_arith u_arith (
    .fn(fn), .a(src_a), .b(src_b),
    .word_res(word_res), .add_res(add_res), .cmp_res(cmp_res), .cond_met(cond_met)
  );

  bmalu_logic u_logic (.grp(grp), .fn(fn), .a(src_a), .b(src_b), .res(logic_res));

  always_comb begin
    result = '0;
    if (op_legal) begin
      case (grp)
        GRP_SHIFT:                    result = shift_res;
        GRP_WORD:                     result = word_res;
        GRP_ADD:                      result = add_res;
        GRP_CMP:                      result = cmp_res;
        GRP_LOGA, GRP_LOGB, GRP_LOGT: result = logic_res;
        default:                      result = '0;
      endcase
    end
  end

  assign br_taken = op_legal && (grp == GRP_BR) && cond_met;
endmodule

// File: rtl/bmalu_checks.sv
module bmalu_checks
  import bmalu_pkg::*;
(
  input logic [OP_W-1:0] op_code,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] result,
  input logic            br_taken,
  input grp_e            grp,
  input logic            op_legal
);
  always_comb begin
    // R1: an undefined code drives nothing
    p_undef_quiet_r1: assert (op_legal || (result == '0 && !br_taken))
      else $error("undefined opcode produced output");
    // R12: the flag only rises for branch codes, whose result is zero
    p_taken_only_branch_r12: assert (grp == GRP_BR || !br_taken)
      else $error("taken flag outside branch group");
    p_branch_result_zero_r12: assert (grp != GRP_BR || result == '0)
      else $error("branch code produced a result");
    // R4: word results are sign-extended from bit 31
    p_word_sext_r4: assert (!(op_legal && grp == GRP_WORD && op_code[3:2] != 2'b01)
                            || result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}})
      else $error("word result not sign-extended");
    // R11: truncated logic leaves the upper bits clear
    p_trunc_width_r11: assert (!(op_legal && grp == GRP_LOGT)
                               || (op_code[0] ? result[XLEN-1:HLEN] == '0 : result[XLEN-1:1] == '0))
      else $error("truncated logic result too wide");
    // R8: min/max pick one operand, set-less-than yields one bit
    p_minmax_pick_r8: assert (!(op_legal && grp == GRP_CMP && op_code[2])
                              || result == src_a || result == src_b)
      else $error("min/max result is neither operand");
    p_setless_bit_r8: assert (!(grp == GRP_CMP && op_code[3:0] inside {4'd1, 4'd2})
                              || result[XLEN-1:1] == '0)
      else $error("set-less-than result too wide");
    // R3: rotate by zero returns the operand
    p_rot_zero_r3: assert (!(op_code inside {7'h08, 7'h09} && src_b[SH_W-1:0] == '0)
                           || result == src_a)
      else $error("rotate by zero changed operand");
  end
endmodule

bind bmalu_top bmalu_checks u_bmalu_checks (
  .op_code(op_code), .src_a(src_a), .src_b(src_b), .result(result),
  .br_taken(br_taken), .grp(grp), .op_legal(op_legal)
);

// File: tb/test_bmalu_top.sv
module test_bmalu_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  op = '0;
  logic [63:0] s1 = '0, s2 = '0;
  logic [63:0] res;
  logic        tk;
  int          n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmalu_top i_bmalu_top (.op_code(op), .src_a(s1), .src_b(s2), .result(res), .br_taken(tk));

  function automatic logic [63:0] sx32(input logic [63:0] v);
    logic [63:0] r;
    r = v;
    for (int k = 32; k < 64; k++) r[k] = v[31];
    return r;
  endfunction

  // 0 and, 1 or, 2 xor, 3 byte-or-combine
  function automatic logic [63:0] tlogic(input int idx, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    if (idx == 0) r = a & b;
    else if (idx == 1) r = a | b;
    else if (idx == 2) r = a ^ b;
    else for (int k = 0; k < 8; k++) if (a[k*8 +: 8] != 8'h00) r[k*8 +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic void ref_alu(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] r, output logic t, output bit def);
    int sh, sw, n;
    logic [63:0] lo, sum, tmp;
    logic [31:0] w, wr;
    logic [63:0] am, bm;
    sh = int'(b[5:0]); sw = int'(b[4:0]);
    lo = {32'h0, a[31:0]}; sum = a + b;
    am = a ^ 64'h8000_0000_0000_0000; bm = b ^ 64'h8000_0000_0000_0000;
    r = '0; t = 1'b0; def = 1'b1;
    case (o)
      7'h00: r = lo << sh;
      7'h01: r = a << sh;
      7'h02: begin r = a; r[sh] = 1'b0; end
      7'h03: begin r = a; r[sh] = 1'b1; end
      7'h04: begin r = a; r[sh] = ~a[sh]; end
      7'h05: r = a >> sh;
      7'h06: r[0] = a[sh];
      7'h07: begin r = a >> sh; if (a[63]) for (int k = 0; k < sh; k++) r[63-k] = 1'b1; end
      7'h08: for (int k = 0; k < 64; k++) r[(k+sh)%64] = a[k];
      7'h09: for (int k = 0; k < 64; k++) r[k] = a[(k+sh)%64];
      7'h10: r = sx32(sum);
      7'h11: r = sx32({63'h0, a[0]} + b);
      7'h12: r = sx32(a - b);
      7'h14: r[0] = sum[0];
      7'h15: r[7:0] = sum[7:0];
      7'h16: r[15:0] = sum[15:0];
      7'h17: begin r[15:0] = sum[15:0]; for (int k = 16; k < 64; k++) r[k] = sum[15]; end
      7'h18: r = sx32(a << sw);
      7'h19: r = sx32(lo >> sw);
      7'h1A: begin
        w = a[31:0] >> sw;
        if (a[31]) for (int k = 0; k < sw; k++) w[31-k] = 1'b1;
        r = sx32({32'h0, w});
      end
      7'h1C: begin wr = '0; for (int k = 0; k < 32; k++) wr[(k+sw)%32] = a[k]; r = sx32({32'h0, wr}); end
      7'h1D: begin wr = '0; for (int k = 0; k < 32; k++) wr[k] = a[(k+sw)%32]; r = sx32({32'h0, wr}); end
      7'h20: r = lo + b;
      7'h21: r = sum;
      7'h22: r = {63'h0, a[0]} + b;
      7'h24, 7'h25, 7'h26, 7'h27: begin n = 29 + int'(o) - 'h24; r = (a >> n) + b; end
      7'h28: r = (lo << 1) + b;
      7'h29: r = (a << 1) + b;
      7'h2A: r = (lo << 2) + b;
      7'h2B: r = (a << 2) + b;
      7'h2C: r = (lo << 3) + b;
      7'h2D: r = (a << 3) + b;
      7'h2F: r = (a << 4) + b;
      7'h30: r = a - b;
      7'h31: r[0] = (a < b);
      7'h32: r[0] = (am < bm);
      7'h34: r = (a > b) ? a : b;
      7'h35: r = (a > b) ? b : a;
      7'h36: r = (am > bm) ? a : b;
      7'h37: r = (am > bm) ? b : a;
      7'h40: r = a & b;
      7'h41: r = a & ~b;
      7'h42: r = a | b;
      7'h43: r = a | ~b;
      7'h44: r = a ^ b;
      7'h45: r = ~(a ^ b);
      7'h46: r = tlogic(3, a, b);
      7'h48: begin r[7:0] = a[7:0]; for (int k = 8; k < 64; k++) r[k] = a[7]; end
      7'h49: r[15:0] = {b[7:0], a[7:0]};
      7'h4A: begin r[15:0] = a[15:0]; for (int k = 16; k < 64; k++) r[k] = a[15]; end
      7'h4B: r = sx32({32'h0, b[15:0], a[15:0]});
      7'h50: for (int k = 0; k < 64; k++) r[k] = a[(k/8)*8 + 7 - (k%8)];
      7'h51: for (int k = 0; k < 64; k++) r[k] = a[(7 - k/8)*8 + (k%8)];
      7'h52: r = {b[31:0], a[31:0]};
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
        tmp = tlogic(int'(o[2:1]), a, b);
        if (o[0]) r[15:0] = tmp[15:0]; else r[0] = tmp[0];
      end
      7'h70: t = (a == b);
      7'h72: t = (a != b);
      7'h78: t = (am < bm);
      7'h7A: t = (am >= bm);
      7'h7C: t = (a < b);
      7'h7E: t = (a >= b);
      default: def = 1'b0;
    endcase
  endfunction

  function automatic string req_tag(input logic [6:0] o, input bit def);
    if (!def) return "R1";
    if (o inside {7'h08, 7'h09, 7'h1C, 7'h1D}) return "R3";
    if (o[6:4] == 3'b000) return "R2";
    if (o inside {[7'h14:7'h17]}) return "R5";
    if (o[6:4] == 3'b001) return "R4";
    if (o inside {[7'h20:7'h27]}) return "R6";
    if (o[6:4] == 3'b010) return "R7";
    if (o[6:4] == 3'b011) return "R8";
    if (o inside {[7'h40:7'h46]}) return "R9";
    if (o[6:4] == 3'b100 || o[6:4] == 3'b101) return "R10";
    if (o[6:4] == 3'b110) return "R11";
    return "R12";
  endfunction

  task automatic run_one(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    logic et;
    bit d;
    @(posedge clk);
    #1;
    op = o; s1 = a; s2 = b;
    @(negedge clk);
    ref_alu(o, a, b, er, et, d);
    n_cmp++;
    if (res !== er || tk !== et) begin
      n_bad++;
      $display("FAIL %s op=%02h a=%016h b=%016h: got result=%016h taken=%b, expected result=%016h taken=%b",
               req_tag(o, d), o, a, b, res, tk, er, et);
    end
  endtask

  logic [63:0] corners [9];

  initial begin
    corners[0] = 64'h0;
    corners[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    corners[2] = 64'h8000_0000_0000_0000;
    corners[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    corners[4] = 64'h1;
    corners[5] = 64'd31;
    corners[6] = 64'd32;
    corners[7] = 64'd63;
    corners[8] = 64'h0000_0000_8000_0000;

    // reset state: idle inputs give a zero result and no branch
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (res !== 64'h0 || tk !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 reset state: got result=%016h taken=%b, expected result=0 taken=0", res, tk);
    end
    rst_n = 1'b1;

    // corner grid over every opcode value, defined or not (R1..R12)
    for (int o = 0; o < 128; o++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++)
          run_one(7'(o), corners[i], corners[j]);

    // random operands on every opcode value
    for (int o = 0; o < 128; o++)
      for (int k = 0; k < 40; k++)
        run_one(7'(o), {$urandom, $urandom}, {$urandom, $urandom});

    // equal operands for the branch comparisons (R12)
    for (int k = 0; k < 20; k++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      run_one(7'h70, v, v); run_one(7'h72, v, v); run_one(7'h7A, v, v); run_one(7'h7E, v, v);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got %0d cycles, expected fewer", MAX_CYCLES);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule